// File: doc/BRIEF.md
# Flash Command and Control Register

This block is the command register of an embedded flash controller. Software writes it over a simple register bus to choose a program width, load protection keys and request a program, page-erase or mass-erase operation. When the keys are right, the block sends one single-cycle start strobe, with an operation code and a width flag, to the flash macro. It then reports busy until the macro returns a done pulse.

While an operation is pending or running, the block shuts off register writes for the whole controller. Its own fields stay frozen, and the write enable it passes to the neighbouring registers is held low. The one exception is the interrupt register, which remains writable. A command that arrives with the wrong keys is dropped and raises a sticky access-error flag. When the macro finishes, the block clears the command bits and both keys by itself. The block also holds a low-voltage enable bit that goes straight out to the flash macro.

Top module: `flash_cmd_reg`

## Requirements
- R1: After reset the read value is 0, and `mac_start`, `acc_err` and `lv_en` are 0.
- R2: Read layout: program command bit 0, mass-erase command bit 1, page-erase command bit 2, width bit 4 (0 = 128-bit, 1 = 32-bit), erase key bits 15:8, busy bit 16 (read-only), low-voltage enable bit 25 (drives `lv_en`), unlock key bits 31:28. Every other bit reads 0, whatever was written to it.
- R3: A command is pending while any command bit reads 1. A program command is accepted when the unlock key is 2. One clock edge after the write is captured, `mac_start` is 1, `mac_op` is 0 and busy reads 1. `mac_w32` follows the width bit.
- R4: A page erase is accepted when the unlock key is 2 and the erase key is 0x55. It drives `mac_op` = 1. A mass erase also needs erase key 0xAA and `dbg_en` = 1. It drives `mac_op` = 2.
- R5: When several command bits are set in one write, only one operation starts. Mass erase has priority, then page erase, then program.
- R6: A command whose keys are wrong is dropped one edge after capture: no start strobe, busy stays 0, all command bits read 0, and `acc_err` becomes 1 and stays 1 until reset.
- R7: Busy stays 1 until `mac_done` is seen. A `mac_done` pulse while idle changes nothing.
- R8: On `mac_done` while busy, busy, the command bits, the erase key and the unlock key all become 0. The width bit and the low-voltage enable keep their values.
- R9: While busy or pending, a write to the control address changes nothing and `wr_pass` is 0. Only a write to the interrupt address gives `wr_pass` = 1. When idle, `wr_pass` equals `bus_we` for any address.
- R10: `mac_start` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | 32 | Write data |
| ctrl_rdata | output | 32 | Current value of the control register |
| wr_pass | output | 1 | Gated write enable for all controller registers |
| dbg_en | input | 1 | Debug port enabled; a mass erase needs it |
| mac_start | output | 1 | Single-cycle operation start to the flash macro |
| mac_op | output | 2 | Operation: 0 program, 1 page erase, 2 mass erase |
| mac_w32 | output | 1 | Program width: 1 = 32-bit, 0 = 128-bit |
| mac_done | input | 1 | Operation-complete pulse from the macro |
| lv_en | output | 1 | Low-voltage enable |
| acc_err | output | 1 | Sticky flag for a dropped command |

## Verification
Each operation is requested with the correct keys, then with one key wrong at a time: a locked unlock field, a swapped erase key, and mass erase with the debug port off. This shows that every guard is checked on its own. Writes that set several command bits at once show the priority order, because the operation code that comes out differs in each case. Writes during the pending cycle, during the busy cycles and to the interrupt address show which writes get through. A stray done pulse while idle shows that completion is tied to a running operation.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_PAGE = 2'd1,
        OP_MASS = 2'd2
    } fop_e;

    localparam int B_WR    = 0;
    localparam int B_ME    = 1;
    localparam int B_PE    = 2;
    localparam int B_W32   = 4;
    localparam int B_EC_LO = 8;
    localparam int EC_W    = 8;
    localparam int B_BUSY  = 16;
    localparam int B_LVE   = 25;
    localparam int B_UL_LO = 28;
    localparam int UL_W    = 4;

    typedef struct packed {
        logic             wr;
        logic             me;
        logic             pe;
        logic             w32;
        logic [EC_W-1:0]  ec;
        logic             lve;
        logic [UL_W-1:0]  ul;
        logic             busy;
        logic             start;
        fop_e             op;
        logic             err;
    } ctrl_t;

endpackage

// File: rtl/fc_wr_gate.sv
module fc_wr_gate #(
    parameter int              AW        = 4,
    parameter logic [AW-1:0]   CTRL_ADDR = '0,
    parameter logic [AW-1:0]   INTR_ADDR = '1
) (
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic          blocked,
    output logic          wr_pass,
    output logic          ctrl_wr
);
    logic is_intr;
    logic is_ctrl;

    always_comb begin
        is_intr = (bus_addr == INTR_ADDR);
        is_ctrl = (bus_addr == CTRL_ADDR);
        wr_pass = bus_we && (!blocked || is_intr);
        ctrl_wr = wr_pass && is_ctrl;
    end
endmodule

// File: rtl/fc_cmd_select.sv
module fc_cmd_select
    import flash_cmd_pkg::*;
#(
    parameter logic [UL_W-1:0] UNLOCK_KEY = 4'd2,
    parameter logic [EC_W-1:0] PAGE_KEY   = 8'h55,
    parameter logic [EC_W-1:0] MASS_KEY   = 8'hAA
) (
    input  logic            wr,
    input  logic            pe,
    input  logic            me,
    input  logic [EC_W-1:0] ec,
    input  logic [UL_W-1:0] ul,
    input  logic            dbg_en,
    output logic            any,
    output fop_e            op,
    output logic            ok
);
    logic unlocked;

    always_comb begin
        unlocked = (ul == UNLOCK_KEY);
        any      = wr | pe | me;
        op       = OP_PROG;
        ok       = 1'b0;
        if (me) begin
            op = OP_MASS;
            ok = unlocked && (ec == MASS_KEY) && dbg_en;
        end else if (pe) begin
            op = OP_PAGE;
            ok = unlocked && (ec == PAGE_KEY);
        end else if (wr) begin
            op = OP_PROG;
            ok = unlocked;
        end
    end
endmodule

// File: rtl/fc_rd_pack.sv
module fc_rd_pack
    import flash_cmd_pkg::*;
(
    input  ctrl_t       st,
    output logic [31:0] rdata
);
    always_comb begin
        rdata                        = '0;
        rdata[B_WR]                  = st.wr;
        rdata[B_ME]                  = st.me;
        rdata[B_PE]                  = st.pe;
        rdata[B_W32]                 = st.w32;
        rdata[B_EC_LO +: EC_W]       = st.ec;
        rdata[B_BUSY]                = st.busy;
        rdata[B_LVE]                 = st.lve;
        rdata[B_UL_LO +: UL_W]       = st.ul;
    end
endmodule

// File: rtl/flash_cmd_reg.sv
module flash_cmd_reg
    import flash_cmd_pkg::*;
#(
    parameter int              AW         = 4,
    parameter logic [AW-1:0]   CTRL_ADDR  = 4'h2,
    parameter logic [AW-1:0]   INTR_ADDR  = 4'h9,
    parameter logic [3:0]      UNLOCK_KEY = 4'd2,
    parameter logic [7:0]      PAGE_KEY   = 8'h55,
    parameter logic [7:0]      MASS_KEY   = 8'hAA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   ctrl_rdata,
    output logic          wr_pass,
    input  logic          dbg_en,
    output logic          mac_start,
    output logic [1:0]    mac_op,
    output logic          mac_w32,
    input  logic          mac_done,
    output logic          lv_en,
    output logic          acc_err
);
    ctrl_t q, d;
    logic  cmd_any, cmd_ok, ctrl_wr, blocked;
    fop_e  sel_op;

    assign blocked = q.busy | cmd_any;

    fc_wr_gate #(
        .AW(AW), .CTRL_ADDR(CTRL_ADDR), .INTR_ADDR(INTR_ADDR)
    ) u_gate (
        .bus_we(bus_we), .bus_addr(bus_addr), .blocked(blocked),
        .wr_pass(wr_pass), .ctrl_wr(ctrl_wr)
    );

    fc_cmd_select #(
        .UNLOCK_KEY(UNLOCK_KEY), .PAGE_KEY(PAGE_KEY), .MASS_KEY(MASS_KEY)
    ) u_sel (
        .wr(q.wr), .pe(q.pe), .me(q.me), .ec(q.ec), .ul(q.ul),
        .dbg_en(dbg_en), .any(cmd_any), .op(sel_op), .ok(cmd_ok)
    );

    fc_rd_pack u_pack (
        .st(q), .rdata(ctrl_rdata)
    );

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (q.busy) begin
            if (mac_done) begin
                d.busy = 1'b0;
                d.wr   = 1'b0;
                d.me   = 1'b0;
                d.pe   = 1'b0;
                d.ec   = '0;
                d.ul   = '0;
            end
        end else if (cmd_any) begin
            if (cmd_ok) begin
                d.busy  = 1'b1;
                d.start = 1'b1;
                d.op    = sel_op;
            end else begin
                d.wr  = 1'b0;
                d.me  = 1'b0;
                d.pe  = 1'b0;
                d.err = 1'b1;
            end
        end else if (ctrl_wr) begin
            d.wr  = bus_wdata[B_WR];
            d.me  = bus_wdata[B_ME];
            d.pe  = bus_wdata[B_PE];
            d.w32 = bus_wdata[B_W32];
            d.ec  = bus_wdata[B_EC_LO +: EC_W];
            d.lve = bus_wdata[B_LVE];
            d.ul  = bus_wdata[B_UL_LO +: UL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{wr: 1'b0, me: 1'b0, pe: 1'b0, w32: 1'b0, ec: '0, lve: 1'b0,
                   ul: '0, busy: 1'b0, start: 1'b0, op: OP_PROG, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign mac_start = q.start;
    assign mac_op    = q.op;
    assign mac_w32   = q.w32;
    assign lv_en     = q.lve;
    assign acc_err   = q.err;

endmodule

// File: rtl/fc_cmd_checker.sv
module fc_cmd_checker #(
    parameter int            AW        = 4,
    parameter logic [AW-1:0] INTR_ADDR = 4'h9
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic [31:0]   ctrl_rdata,
    input logic          wr_pass,
    input logic          dbg_en,
    input logic          mac_start,
    input logic [1:0]    mac_op,
    input logic          mac_done,
    input logic          acc_err
);
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mac_start |=> !mac_start); // R10

    AST_START_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        mac_start |-> (ctrl_rdata[31:28] == 4'd2 && ctrl_rdata[16])); // R3

    AST_MASS_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_start && mac_op == 2'd2) |-> (ctrl_rdata[15:8] == 8'hAA && $past(dbg_en))); // R4

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[16] && !mac_done) |=> ctrl_rdata[16]); // R7

    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[16] && mac_done) |=> (!ctrl_rdata[16] && ctrl_rdata[2:0] == 3'b000
                                          && ctrl_rdata[15:8] == 8'h00)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |=> acc_err); // R6

    AST_WR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[16] && wr_pass) |-> (bus_addr == INTR_ADDR)); // R9
endmodule

bind flash_cmd_reg fc_cmd_checker #(.AW(AW), .INTR_ADDR(INTR_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .ctrl_rdata(ctrl_rdata),
    .wr_pass(wr_pass), .dbg_en(dbg_en), .mac_start(mac_start), .mac_op(mac_op),
    .mac_done(mac_done), .acc_err(acc_err)
);

// File: tb/sim_flash_cmd_reg.sv
module sim_flash_cmd_reg;
    localparam int         AW    = 4;
    localparam logic [3:0] CTRL  = 4'h2;
    localparam logic [3:0] INTR  = 4'h9;
    localparam logic [3:0] OTHER = 4'h5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] ctrl_rdata;
    logic        wr_pass, dbg_en = 1'b0, mac_start, mac_w32, mac_done = 1'b0, lv_en, acc_err;
    logic [1:0]  mac_op;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    flash_cmd_reg #(.AW(AW), .CTRL_ADDR(CTRL), .INTR_ADDR(INTR)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .ctrl_rdata(ctrl_rdata), .wr_pass(wr_pass),
        .dbg_en(dbg_en), .mac_start(mac_start), .mac_op(mac_op),
        .mac_w32(mac_w32), .mac_done(mac_done), .lv_en(lv_en), .acc_err(acc_err)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] ul, input logic lve,
            input logic [7:0] ec, input logic w32, input logic pe,
            input logic me, input logic wr);
        return {ul, 2'b00, lve, 9'd0, ec, 3'd0, w32, 1'b0, pe, me, wr};
    endfunction

    task automatic bus_write(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        mac_done = 1'b1;
        @(negedge clk);
        mac_done = 1'b0;
    endtask

    task automatic run_ok(input logic [31:0] v, input logic [1:0] eop, input string req);
        bus_write(CTRL, v);
        chk(ctrl_rdata[2:0] != 3'b000 && !ctrl_rdata[16], req, ctrl_rdata, v);
        @(negedge clk);
        chk(mac_start && ctrl_rdata[16], req, {30'd0, mac_start, ctrl_rdata[16]}, 32'd3);
        chk(mac_op == eop, req, {30'd0, mac_op}, {30'd0, eop});
        @(negedge clk);
        chk(!mac_start, "R10", {31'd0, mac_start}, 32'd0);
    endtask

    task automatic t_reset();
        chk(ctrl_rdata == 32'd0 && !mac_start && !acc_err && !lv_en, "R1",
            ctrl_rdata, 32'd0);
    endtask

    task automatic t_fields();
        bus_write(CTRL, mk(4'h3, 1'b1, 8'h12, 1'b1, 1'b0, 1'b0, 1'b0) | 32'h00C0_00E8);
        chk(ctrl_rdata == 32'h3200_1210, "R2", ctrl_rdata, 32'h3200_1210);
        chk(lv_en && mac_w32, "R2", {30'd0, lv_en, mac_w32}, 32'd3);
        bus_write(CTRL, 32'd0);
    endtask

    task automatic t_program();
        run_ok(mk(4'd2, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1), 2'd0, "R3");
        chk(mac_w32, "R3", {31'd0, mac_w32}, 32'd1);
        repeat (3) @(negedge clk);
        chk(ctrl_rdata[16], "R7", ctrl_rdata, 32'h0001_0000);
        pulse_done();
        chk(ctrl_rdata == 32'h0200_0010, "R8", ctrl_rdata, 32'h0200_0010);
        bus_write(CTRL, 32'd0);
    endtask

    task automatic t_erase();
        run_ok(mk(4'd2, 1'b0, 8'h55, 1'b0, 1'b1, 1'b0, 1'b0), 2'd1, "R4");
        pulse_done();
        chk(ctrl_rdata == 32'd0, "R8", ctrl_rdata, 32'd0);
        dbg_en = 1'b1;
        run_ok(mk(4'd2, 1'b0, 8'hAA, 1'b0, 1'b0, 1'b1, 1'b0), 2'd2, "R4");
        pulse_done();
        chk(ctrl_rdata == 32'd0, "R8", ctrl_rdata, 32'd0);
    endtask

    task automatic t_precedence();
        dbg_en = 1'b1;
        run_ok(mk(4'd2, 1'b0, 8'hAA, 1'b0, 1'b1, 1'b1, 1'b1), 2'd2, "R5");
        pulse_done();
        run_ok(mk(4'd2, 1'b0, 8'h55, 1'b0, 1'b1, 1'b0, 1'b1), 2'd1, "R5");
        pulse_done();
        chk(ctrl_rdata[16] == 1'b0, "R5", ctrl_rdata, 32'd0);
    endtask

    task automatic t_reject(input logic [31:0] v, input logic dbg);
        dbg_en = dbg;
        bus_write(CTRL, v);
        @(negedge clk);
        chk(!mac_start && ctrl_rdata[2:0] == 3'b000 && !ctrl_rdata[16], "R6",
            ctrl_rdata, v & 32'hFFFF_FFF8);
        chk(acc_err, "R6", {31'd0, acc_err}, 32'd1);
        repeat (2) @(negedge clk);
        chk(!mac_start && !ctrl_rdata[16] && acc_err, "R6",
            {30'd0, mac_start, ctrl_rdata[16]}, 32'd0);
        bus_write(CTRL, 32'd0);
    endtask

    task automatic t_gate();
        @(negedge clk);
        bus_we = 1'b1; bus_addr = OTHER;
        #1 chk(wr_pass, "R9", {31'd0, wr_pass}, 32'd1);
        bus_we = 1'b0;
        bus_write(CTRL, mk(4'd2, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1));
        bus_we = 1'b1; bus_addr = CTRL; bus_wdata = 32'h0200_0000;
        #1 chk(!wr_pass, "R9", {31'd0, wr_pass}, 32'd0);
        @(negedge clk);
        #1 chk(!wr_pass && ctrl_rdata[16], "R9", {31'd0, wr_pass}, 32'd0);
        @(negedge clk);
        bus_addr = INTR;
        #1 chk(wr_pass, "R9", {31'd0, wr_pass}, 32'd1);
        bus_addr = OTHER;
        #1 chk(!wr_pass, "R9", {31'd0, wr_pass}, 32'd0);
        @(negedge clk);
        bus_we = 1'b0;
        chk(!ctrl_rdata[25] && !lv_en, "R9", ctrl_rdata, 32'h2001_0001);
        pulse_done();
        chk(ctrl_rdata == 32'd0, "R8", ctrl_rdata, 32'd0);
    endtask

    task automatic t_idle_done();
        bus_write(CTRL, mk(4'd2, 1'b1, 8'h55, 1'b1, 1'b0, 1'b0, 1'b0));
        pulse_done();
        @(negedge clk);
        chk(ctrl_rdata == 32'h2200_5510 && !mac_start, "R7", ctrl_rdata, 32'h2200_5510);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_program();
        t_erase();
        t_precedence();
        t_gate();
        t_idle_done();
        bus_write(CTRL, 32'd0);
        t_reject(mk(4'd3, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1), 1'b1);
        t_reject(mk(4'd2, 1'b0, 8'hAA, 1'b0, 1'b1, 1'b0, 1'b0), 1'b1);
        t_reject(mk(4'd2, 1'b0, 8'hAA, 1'b0, 1'b0, 1'b1, 1'b0), 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule